// File: doc/BRIEF.md
# Dual-Bank Interleaved Virtual-Channel Input Buffer

This block is the storage at one input port of a virtual-channel router. It takes one flit per clock cycle. Each storage bank, however, needs two cycles to finish a write. Every virtual channel keeps its FIFO in two banks. The even bank holds the even slot addresses and the odd bank holds the odd ones, so the two banks together form one contiguous queue. Each arriving flit first goes into an input register. From there it moves into one of two write paths, which take turns: a path is loaded on every second cycle and holds its flit steady for two cycles while its bank completes the write. Consecutive flits may name different virtual channels, because each path decodes its own channel number.

The bank is chosen per channel at the cycle the flit enters a write path. If one bank of that channel is still being written by the other path, the flit goes to the other bank. If neither bank is busy, the parity of the tail pointer decides. The tail pointer records the most recently allocated slot; an odd tail picks the even bank and an even tail picks the odd bank. A flit bound for an empty channel is also offered on a bypass output while it sits in the input register. If the switch takes it there, it is never stored. Otherwise it is buffered as usual. Each channel has one read port toward the switch. A slot becomes readable only after its two-cycle write has completed. A flit sent to a full channel is dropped and flagged.

Top module: `vcbuf_dual_bank`

## Requirements
- R1: A new flit is accepted on every cycle. A back-to-back burst to one channel, up to the channel depth, is stored completely with no flit lost.
- R2: A flit presented with `in_valid` before clock edge k and not taken by bypass raises `rd_valid` of its channel after edge k+3 and not earlier.
- R3: Slot addresses of a channel are used in order and contiguously. The write path that holds slot s targets the even bank (bank code 0) when s is even and the odd bank (bank code 1) when s is odd.
- R4: Within one channel, the two write paths never target the same bank at the same time.
- R5: While `rd_valid` of a channel is high and its `rd_en` is low, the channel's `rd_flit` and `rd_valid` hold their values on the next cycle.
- R6: Each channel returns its flits in arrival order. Every accepted read advances to the next slot. After the last stored flit has been read, `rd_valid` is low.
- R7: While a flit sits in the input register and its channel is empty, `byp_valid` is high and `byp_vc` and `byp_flit` carry it. If `byp_grant` is high in that cycle, the flit is not stored and its channel stays empty.
- R8: A bypass offer that is not granted leaves the flit to be buffered and read out normally, as in R2.
- R9: A flit that reaches the input register while its channel holds DEPTH flits raises `err_full` for exactly one cycle, after the next edge. The flit is discarded and the stored flits are unchanged.
- R10: After reset `rd_valid`, `byp_valid` and `err_full` are all low.
- R11: Flits interleaved between channels each land in their own channel's queue, in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A flit is present this cycle |
| in_vc | input | VCW | Virtual channel of the flit |
| in_flit | input | FLIT_W | Flit payload |
| byp_grant | input | 1 | Switch takes the flit offered on the bypass |
| byp_valid | output | 1 | A flit for an empty channel is offered on the bypass |
| byp_vc | output | VCW | Channel of the offered flit |
| byp_flit | output | FLIT_W | Offered flit |
| rd_en | input | NUM_VC | Per-channel read request from the switch |
| rd_valid | output | NUM_VC | Per-channel head flit present and fully written |
| rd_flit | output | NUM_VC*FLIT_W | Per-channel head flit; channel v in bits v*FLIT_W upward |
| err_full | output | 1 | One-cycle pulse: flit to a full channel was dropped |

## Verification
Some properties are checked on every cycle. The write path's bank must match the parity of its slot. The two paths must never share one bank of one channel. A bypass offer must never coincide with readable data on that channel. Unread head data must hold steady. An error pulse must follow a flit in the input register. Other behaviour shows only in the directed scenarios: the exact four-edge latency before a slot becomes readable, FIFO order across bursts and interleaved channels, the discarding of a granted bypass flit, and the single error pulse with the contents kept intact when a channel overflows.

// File: rtl/vcb_pkg.sv
package vcb_pkg;

  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;

  // Busy port wins; with both idle, an odd last-allocated slot picks even.
  function automatic bank_e pick_bank(input logic busy_even,
                                      input logic busy_odd,
                                      input logic tail_lsb);
    bank_e b;
    if (busy_even)      b = BANK_ODD;
    else if (busy_odd)  b = BANK_EVEN;
    else if (tail_lsb)  b = BANK_EVEN;
    else                b = BANK_ODD;
    return b;
  endfunction

endpackage

// File: rtl/vcb_in_stage.sv
module vcb_in_stage #(
  parameter int VCW = 2,
  parameter int FW  = 128,
  parameter int SW  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [VCW-1:0]           in_vc,
  input  logic [FW-1:0]            in_flit,
  output logic                     r_valid,
  output logic [VCW-1:0]           r_vc,
  output logic [FW-1:0]            r_flit,
  input  logic                     take,
  input  logic                     ld_bank,
  input  logic [SW-1:0]            ld_slot,
  output logic                     sel,
  output logic [1:0]               path_valid,
  output logic [1:0][VCW-1:0]      path_vc,
  output logic [1:0]               path_bank,
  output logic [1:0][SW-1:0]       path_slot,
  output logic [1:0][FW-1:0]       path_flit
);

  logic r_valid_d;
  logic sel_d;

  always_comb begin
    r_valid_d = in_valid;
    sel_d     = ~sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      sel     <= 1'b0;
    end else begin
      r_valid <= r_valid_d;
      sel     <= sel_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      r_vc   <= in_vc;
      r_flit <= in_flit;
    end
  end

  // Each path reloads on alternate edges and holds its flit for two cycles.
  for (genvar k = 0; k < 2; k++) begin : g_path
    logic ld_en;
    logic vld_d;

    always_comb begin
      ld_en = (sel == k[0]);
      vld_d = ld_en ? take : path_valid[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) path_valid[k] <= 1'b0;
      else        path_valid[k] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (ld_en && take) begin
        path_vc[k]   <= r_vc;
        path_bank[k] <= ld_bank;
        path_slot[k] <= ld_slot;
        path_flit[k] <= r_flit;
      end
    end
  end

endmodule

// File: rtl/vcb_vc_store.sv
module vcb_vc_store
  import vcb_pkg::*;
#(
  parameter int FW    = 128,
  parameter int DEPTH = 8,
  localparam int SW   = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc,
  input  logic           busy_even,
  input  logic           busy_odd,
  output logic           sel_bank,
  output logic [SW-1:0]  next_slot,
  output logic           empty,
  output logic           full,
  input  logic           wr_en,
  input  logic           wr_bank,
  input  logic [SW-1:0]  wr_slot,
  input  logic [FW-1:0]  wr_flit,
  input  logic           rd_en,
  output logic           rd_valid,
  output logic [FW-1:0]  rd_flit
);

  logic [SW:0]   head_q, head_d;
  logic [SW:0]   tail_q, tail_d;   // most recently allocated slot
  logic [SW:0]   nxt;
  logic [SW:0]   fill;
  logic [1:0][HALF-1:0] rdy_q, rdy_d;
  logic [1:0][FW-1:0]   bank_rd;
  logic          rd_fire;

  always_comb begin
    nxt       = tail_q + 1'b1;
    fill      = nxt - head_q;
    empty     = (fill == '0);
    full      = (fill == (SW+1)'(DEPTH));
    next_slot = nxt[SW-1:0];
    sel_bank  = pick_bank(busy_even, busy_odd, tail_q[0]);
  end

  always_comb begin
    rd_valid = !empty && rdy_q[head_q[0]][head_q[SW-1:1]];
    rd_flit  = bank_rd[head_q[0]];
    rd_fire  = rd_en && rd_valid;
    head_d   = rd_fire ? head_q + 1'b1 : head_q;
    tail_d   = alloc   ? nxt          : tail_q;
    rdy_d    = rdy_q;
    if (rd_fire) rdy_d[head_q[0]][head_q[SW-1:1]] = 1'b0;
    if (wr_en)   rdy_d[wr_bank][wr_slot[SW-1:1]]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '1;
      rdy_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      rdy_q  <= rdy_d;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [FW-1:0] mem [HALF];
    logic          we;

    always_comb we = wr_en && (wr_bank == b[0]);

    always_ff @(posedge clk) begin
      if (we) mem[wr_slot[SW-1:1]] <= wr_flit;
    end

    assign bank_rd[b] = mem[head_q[SW-1:1]];
  end

endmodule

// File: rtl/vcbuf_dual_bank.sv
module vcbuf_dual_bank #(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 128,
  parameter int DEPTH  = 8,
  localparam int VCW   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int SW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [VCW-1:0]           in_vc,
  input  logic [FLIT_W-1:0]        in_flit,
  input  logic                     byp_grant,
  output logic                     byp_valid,
  output logic [VCW-1:0]           byp_vc,
  output logic [FLIT_W-1:0]        byp_flit,
  input  logic [NUM_VC-1:0]        rd_en,
  output logic [NUM_VC-1:0]        rd_valid,
  output logic [NUM_VC*FLIT_W-1:0] rd_flit,
  output logic                     err_full
);

  logic                  r_valid;
  logic [VCW-1:0]        r_vc;
  logic [FLIT_W-1:0]     r_flit;
  logic                  take;
  logic                  ld_bank;
  logic [SW-1:0]         ld_slot;
  logic                  sel;
  logic [1:0]            path_valid;
  logic [1:0][VCW-1:0]   path_vc;
  logic [1:0]            path_bank;
  logic [1:0][SW-1:0]    path_slot;
  logic [1:0][FLIT_W-1:0] path_flit;

  logic [NUM_VC-1:0]     vc_empty, vc_full, vc_sel_bank, vc_alloc, vc_wr;
  logic [NUM_VC-1:0]     vc_busy_e, vc_busy_o;
  logic [NUM_VC-1:0][SW-1:0] vc_next;
  logic [1:0][NUM_VC-1:0] path_dec;
  logic                  granted;
  logic                  err_d;
  logic                  wr_bank_c;
  logic [SW-1:0]         wr_slot_c;
  logic [FLIT_W-1:0]     wr_flit_c;

  vcb_in_stage #(.VCW(VCW), .FW(FLIT_W), .SW(SW)) u_in (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
    .r_valid(r_valid), .r_vc(r_vc), .r_flit(r_flit),
    .take(take), .ld_bank(ld_bank), .ld_slot(ld_slot),
    .sel(sel), .path_valid(path_valid), .path_vc(path_vc),
    .path_bank(path_bank), .path_slot(path_slot), .path_flit(path_flit)
  );

  // One channel decoder per write path.
  for (genvar k = 0; k < 2; k++) begin : g_dec
    for (genvar v = 0; v < NUM_VC; v++) begin : g_v
      assign path_dec[k][v] = path_valid[k] && (path_vc[k] == VCW'(v));
    end
  end

  always_comb begin
    byp_valid = r_valid && vc_empty[r_vc];
    byp_vc    = r_vc;
    byp_flit  = r_flit;
    granted   = byp_valid && byp_grant;
    take      = r_valid && !granted && !vc_full[r_vc];
    err_d     = r_valid && !granted && vc_full[r_vc];
    ld_bank   = vc_sel_bank[r_vc];
    ld_slot   = vc_next[r_vc];
    wr_bank_c = path_bank[sel];
    wr_slot_c = path_slot[sel];
    wr_flit_c = path_flit[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_full <= 1'b0;
    else        err_full <= err_d;
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    // The path not loading this edge is mid-write; the loading one commits now.
    always_comb begin
      vc_alloc[v]  = take && (r_vc == VCW'(v));
      vc_wr[v]     = path_dec[sel][v];
      vc_busy_e[v] = path_dec[~sel][v] && (path_bank[~sel] == 1'b0);
      vc_busy_o[v] = path_dec[~sel][v] && (path_bank[~sel] == 1'b1);
    end

    vcb_vc_store #(.FW(FLIT_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n),
      .alloc(vc_alloc[v]),
      .busy_even(vc_busy_e[v]), .busy_odd(vc_busy_o[v]),
      .sel_bank(vc_sel_bank[v]), .next_slot(vc_next[v]),
      .empty(vc_empty[v]), .full(vc_full[v]),
      .wr_en(vc_wr[v]), .wr_bank(wr_bank_c), .wr_slot(wr_slot_c),
      .wr_flit(wr_flit_c),
      .rd_en(rd_en[v]), .rd_valid(rd_valid[v]),
      .rd_flit(rd_flit[v*FLIT_W +: FLIT_W])
    );
  end

endmodule

// File: rtl/vcb_checker.sv
module vcb_checker #(
  parameter int NUM_VC = 4,
  parameter int FLIT_W = 128,
  parameter int VCW    = 2,
  parameter int SW     = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     take,
  input logic                     ld_bank,
  input logic [SW-1:0]            ld_slot,
  input logic [1:0]               path_valid,
  input logic [1:0][VCW-1:0]      path_vc,
  input logic [1:0]               path_bank,
  input logic [1:0][SW-1:0]       path_slot,
  input logic                     r_valid,
  input logic                     byp_valid,
  input logic [VCW-1:0]           byp_vc,
  input logic [NUM_VC-1:0]        rd_en,
  input logic [NUM_VC-1:0]        rd_valid,
  input logic [NUM_VC*FLIT_W-1:0] rd_flit,
  input logic                     err_full
);

  // R3: bank chosen by the busy/parity rule agrees with the slot parity
  p_bank_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (ld_bank == ld_slot[0]));

  // R3: stored path bank matches its slot
  p_path_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    path_valid[0] |-> (path_bank[0] == path_slot[0][0]));

  // R4: the two paths never write one bank of one channel together
  p_one_writer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (path_valid == 2'b11 && path_vc[0] == path_vc[1]) |-> (path_bank[0] != path_bank[1]));

  // R7: a bypass offer implies nothing readable on that channel
  p_byp_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byp_valid |-> !rd_valid[byp_vc]);

  // R9: an error pulse follows a flit in the input register
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_full |-> $past(r_valid));

  for (genvar v = 0; v < NUM_VC; v++) begin : g_hold
    // R5: unread head data stays put
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[v] && !rd_en[v]) |=>
        (rd_valid[v] && $stable(rd_flit[v*FLIT_W +: FLIT_W])));
  end

endmodule

bind vcbuf_dual_bank vcb_checker #(
  .NUM_VC(NUM_VC), .FLIT_W(FLIT_W), .VCW(VCW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .ld_bank(ld_bank), .ld_slot(ld_slot),
  .path_valid(path_valid), .path_vc(path_vc), .path_bank(path_bank),
  .path_slot(path_slot), .r_valid(r_valid), .byp_valid(byp_valid),
  .byp_vc(byp_vc), .rd_en(rd_en), .rd_valid(rd_valid), .rd_flit(rd_flit),
  .err_full(err_full)
);

// File: tb/sim_vcbuf_dual_bank.sv
`timescale 1ns/1ps
module sim_vcbuf_dual_bank;

  localparam int NV = 4;
  localparam int FW = 128;
  localparam int DP = 8;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [1:0]      in_vc;
  logic [FW-1:0]   in_flit;
  logic            byp_grant;
  logic            byp_valid;
  logic [1:0]      byp_vc;
  logic [FW-1:0]   byp_flit;
  logic [NV-1:0]   rd_en;
  logic [NV-1:0]   rd_valid;
  logic [NV*FW-1:0] rd_flit;
  logic            err_full;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vcbuf_dual_bank #(.NUM_VC(NV), .FLIT_W(FW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
    .in_flit(in_flit), .byp_grant(byp_grant), .byp_valid(byp_valid),
    .byp_vc(byp_vc), .byp_flit(byp_flit), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_flit(rd_flit), .err_full(err_full)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [FW-1:0] mk(input int v, input int i);
    return {32'hC0DE0000 + 32'(v), 32'(i), 32'h5A5A0000 + 32'(i * 7), 32'(v * 16 + i)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act,
                     input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  // Drive one flit for a single cycle.
  task automatic drive(input int v, input logic [FW-1:0] f);
    in_valid = 1'b1;
    in_vc    = 2'(v);
    in_flit  = f;
    step();
    in_valid = 1'b0;
  endtask

  // Wait for the head of channel v, compare it, then pop it.
  task automatic pop_check(input int v, input logic [FW-1:0] exp, input string tag);
    int n = 0;
    while (!rd_valid[v] && n < 20) begin
      step();
      n++;
    end
    chk(rd_valid[v] && rd_flit[v*FW +: FW] == exp, tag, rd_flit[v*FW +: FW], exp);
    rd_en[v] = 1'b1;
    step();
    rd_en[v] = 1'b0;
  endtask

  task automatic t_reset;
    chk(rd_valid == '0, "R10 rd_valid", FW'(rd_valid), '0);
    chk(!byp_valid, "R10 byp_valid", FW'(byp_valid), '0);
    chk(!err_full, "R10 err_full", FW'(err_full), '0);
  endtask

  task automatic t_latency;
    logic [FW-1:0] f = mk(0, 1);
    drive(0, f);                                   // edge k passed
    chk(byp_valid && byp_vc == 2'd0 && byp_flit == f, "R7 offer", byp_flit, f);
    step();                                        // k+1
    step();                                        // k+2
    chk(!rd_valid[0], "R2 not before k+3", FW'(rd_valid[0]), '0);
    step();                                        // k+3
    chk(rd_valid[0] && rd_flit[0 +: FW] == f, "R8 buffered after no grant", rd_flit[0 +: FW], f);
    chk(rd_valid[0], "R2 ready at k+3", FW'(rd_valid[0]), 1);
    step();
    chk(rd_valid[0] && rd_flit[0 +: FW] == f, "R5 hold", rd_flit[0 +: FW], f);
    rd_en[0] = 1'b1;
    step();
    rd_en[0] = 1'b0;
    chk(!rd_valid[0], "R6 empty after read", FW'(rd_valid[0]), '0);
  endtask

  task automatic t_burst;
    for (int i = 0; i < 6; i++) begin
      in_valid = 1'b1; in_vc = 2'd1; in_flit = mk(1, i);
      step();
    end
    in_valid = 1'b0;
    for (int i = 0; i < 6; i++) pop_check(1, mk(1, i), "R1 R3 R6 burst order");
    step();
    chk(!rd_valid[1], "R6 drained", FW'(rd_valid[1]), '0);
  endtask

  task automatic t_interleave;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; in_vc = 2'(2 + (i % 2)); in_flit = mk(2 + (i % 2), i);
      step();
    end
    in_valid = 1'b0;
    for (int i = 0; i < 8; i += 2) pop_check(2, mk(2, i), "R11 R4 vc2 order");
    for (int i = 1; i < 8; i += 2) pop_check(3, mk(3, i), "R11 R4 vc3 order");
  endtask

  task automatic t_bypass;
    logic [FW-1:0] f = mk(0, 9);
    byp_grant = 1'b1;
    drive(0, f);
    chk(byp_valid && byp_flit == f, "R7 offer granted", byp_flit, f);
    step();
    byp_grant = 1'b0;
    for (int i = 0; i < 5; i++) step();
    chk(!rd_valid[0], "R7 granted flit not stored", FW'(rd_valid[0]), '0);
  endtask

  task automatic t_full;
    int pulses = 0;
    for (int i = 0; i < DP + 1; i++) begin
      in_valid = 1'b1; in_vc = 2'd3; in_flit = mk(3, 100 + i);
      step();
      if (err_full) pulses++;
    end
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      if (err_full) pulses++;
    end
    chk(pulses == 1, "R9 one error pulse", FW'(pulses), 1);
    for (int i = 0; i < DP; i++) pop_check(3, mk(3, 100 + i), "R9 contents intact");
    step();
    chk(!rd_valid[3], "R9 overflow flit discarded", FW'(rd_valid[3]), '0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_vc = '0; in_flit = '0;
    byp_grant = 1'b0; rd_en = '0;
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_latency();
    t_burst();
    t_interleave();
    t_bypass();
    t_full();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule